// File: doc/BRIEF.md
# VBI Ancillary Packet Formatter for a 10-bit BT.656 Stream

This block turns one line's worth of sliced vertical-blanking data into an ancillary data packet that can be inserted into the horizontal blanking of a 10-bit ITU-R BT.656 stream. A line descriptor is offered first. It carries the line number, the field, a 3-bit data-format code, two pattern-match flags, an error flag, a payload length and a mode bit. The payload bytes then follow on a valid/ready input. The block emits one 10-bit word per cycle whenever it has a word to send, and it marks each word with a valid strobe.

A sliced packet starts with the three-word ancillary flag. The identifier words come next, then the payload bytes and an 8-bit checksum, and zero fill closes the packet at a length that is a whole number of 4-byte words. Every byte-valued word carries its byte on bits [9:2] with bits [1:0] at zero. The packet identifier depends on the field and on whether the line number is below 24. In raw mode the block sends a four-word preamble and then passes the full 10-bit luma samples through unchanged. Raw packets have no identifier words, no checksum and no fill.

Top module: `anc_vbi_fmt`

## Requirements
- R1: While reset is held and after it is released, desc_ready is 1, in_ready is 0 and out_valid is 0.
- R2: Two cycles after a descriptor is accepted (desc_valid and desc_ready high at a clock edge), out_word is 000h. A sliced packet's first three words are 000h, 3FFh, 3FFh.
- R3: The fourth word of a sliced packet carries the identifier on bits [9:2]. The value is 91h for field bit 0 with line < 24, 53h for field bit 0 with line >= 24, 55h for field bit 1 with line < 24, and 97h for field bit 1 with line >= 24.
- R4: The fifth word carries {5'b0, format code} on bits [9:2].
- R5: The sixth word carries N = ceil((len + 1) / 4) on bits [9:2]. This is the count of 4-byte words that follow the 8-word header and hold the data, the checksum and the fill.
- R6: The seventh word carries line[7:0]. The eighth carries {3'b0, err, match1, match2, line[9:8]} (bit 4 error, bit 3 match-1, bit 2 match-2, bits 1:0 line[9:8]). Both sit on bits [9:2].
- R7: In sliced mode each accepted input byte in_data[7:0] appears as {byte, 2'b00} on the cycle after acceptance, in arrival order. in_data[9:8] is ignored.
- R8: The word right after the last data byte carries the modulo-256 sum of all data bytes on bits [9:2]. With len = 0 the value is 00h.
- R9: Words of value 000h follow the checksum until the packet holds 8 + 4N words.
- R10: In raw mode the packet is 000h, 3FFh, 3FFh, 180h, followed by the len accepted 10-bit samples unchanged. No checksum or fill follows.
- R11: desc_ready is high only while no packet is in progress. in_ready is high only during the payload phase, and never together with desc_ready. A cycle in the payload phase with in_valid low produces no output word on the next cycle.
- R12: out_valid is low on the cycle after any cycle in which desc_ready is high, so no word appears between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Line descriptor offered |
| desc_ready | output | 1 | Formatter idle, descriptor can be taken |
| desc_raw | input | 1 | 1 = raw luma mode, 0 = sliced mode |
| desc_field | input | 1 | 0 = first field, 1 = second field |
| desc_line | input | 10 | Video line number |
| desc_fmt | input | 3 | Data-format code of the line |
| desc_match1 | input | 1 | Match-1 flag |
| desc_match2 | input | 1 | Match-2 flag |
| desc_err | input | 1 | Error-detected flag |
| desc_len | input | 8 | Number of payload bytes or samples |
| in_valid | input | 1 | Payload item offered |
| in_ready | output | 1 | Payload item can be taken |
| in_data | input | 10 | Payload item (byte on [7:0] in sliced mode) |
| out_valid | output | 1 | out_word holds a packet word |
| out_word | output | 10 | Packet word |

## Verification
A wrong phase or a wrong word index inside the formatter puts the wrong word in one packet slot. A reference queue of expected words catches this at the first misplaced word, no more than one cycle after the faulty state. A stale checksum accumulator or a miscounted fill position is different. It stays hidden until the tail of the packet, so the stimulus mixes lengths where data plus checksum ends exactly on a 4-byte boundary with lengths where it does not. A wrong identifier choice shows only when field and line region vary, so lines 23 and 24 and lines above 255 are both used.

// File: rtl/anc_pkg.sv
package anc_pkg;

    localparam int LINE_W    = 10;
    localparam int LEN_W     = 8;
    localparam int FMT_W     = 3;
    localparam int WORD_W    = 10;
    localparam int BYTE_W    = 8;
    localparam int HIDX_W    = 3;
    localparam int POS_W     = 2;
    localparam int LATE_LINE = 24;

    localparam logic [WORD_W-1:0] FLAG_LO  = 10'h000;
    localparam logic [WORD_W-1:0] FLAG_HI  = 10'h3FF;
    localparam logic [WORD_W-1:0] RAW_MARK = 10'h180;

    localparam logic [HIDX_W-1:0] HDR_LAST_SLICED = 3'd7;
    localparam logic [HIDX_W-1:0] HDR_LAST_RAW    = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_CSUM,
        ST_FILL
    } anc_state_e;

    typedef struct packed {
        logic              raw;
        logic              field2;
        logic [LINE_W-1:0] line;
        logic [FMT_W-1:0]  fmt;
        logic              match1;
        logic              match2;
        logic              err;
        logic [LEN_W-1:0]  len;
    } anc_desc_t;

    // place a byte on the upper eight lanes of a word
    function automatic logic [WORD_W-1:0] byte_word(input logic [BYTE_W-1:0] b);
        return {b, 2'b00};
    endfunction

    // identifier chosen by field and line region
    function automatic logic [BYTE_W-1:0] did_code(input logic field2, input logic late);
        logic [BYTE_W-1:0] r;
        case ({field2, late})
            2'b00:   r = 8'h91;
            2'b01:   r = 8'h53;
            2'b10:   r = 8'h55;
            default: r = 8'h97;
        endcase
        return r;
    endfunction

    // words of four bytes needed for data plus checksum
    function automatic logic [BYTE_W-1:0] word_count(input logic [LEN_W-1:0] len);
        logic [LEN_W+1:0] t;
        t = {2'b00, len} + 10'd4;
        return t[LEN_W+1:2];
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input anc_desc_t d);
        return {3'b000, d.err, d.match1, d.match2, d.line[9:8]};
    endfunction

endpackage

// File: rtl/anc_desc_reg.sv
module anc_desc_reg
    import anc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  anc_desc_t d_in,
    output anc_desc_t d_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else if (load) begin
            d_q <= d_in;
        end
    end
endmodule

// File: rtl/anc_seq.sv
module anc_seq
    import anc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_fire,
    input  logic              raw,
    input  logic [LEN_W-1:0]  len,
    input  logic              in_valid,
    output anc_state_e        state,
    output logic [HIDX_W-1:0] hidx,
    output logic              emit,
    output logic              data_fire,
    output logic              desc_ready,
    output logic              in_ready
);
    anc_state_e        st_q, st_d;
    logic [HIDX_W-1:0] hidx_q;
    logic [LEN_W-1:0]  dcnt_q;
    logic [POS_W-1:0]  pos_q;
    logic              hdr_last;
    logic              data_last;
    logic              pos_wrap;

    assign state      = st_q;
    assign hidx       = hidx_q;
    assign desc_ready = (st_q == ST_IDLE);
    assign in_ready   = (st_q == ST_DATA);
    assign data_fire  = in_ready && in_valid;
    assign hdr_last   = raw ? (hidx_q == HDR_LAST_RAW) : (hidx_q == HDR_LAST_SLICED);
    assign data_last  = (dcnt_q == (len - 8'd1));
    assign pos_wrap   = (pos_q == 2'd3);

    always_comb begin
        case (st_q)
            ST_HDR, ST_CSUM, ST_FILL: emit = 1'b1;
            ST_DATA:                  emit = in_valid;
            default:                  emit = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (desc_fire) st_d = ST_HDR;
            ST_HDR: begin
                if (hdr_last) begin
                    if (len != '0) st_d = ST_DATA;
                    else           st_d = raw ? ST_IDLE : ST_CSUM;
                end
            end
            ST_DATA: begin
                if (in_valid && data_last) st_d = raw ? ST_IDLE : ST_CSUM;
            end
            ST_CSUM: st_d = pos_wrap ? ST_IDLE : ST_FILL;
            ST_FILL: if (pos_wrap) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hidx_q <= '0;
            dcnt_q <= '0;
            pos_q  <= '0;
        end else begin
            st_q <= st_d;
            if (desc_fire) begin
                hidx_q <= '0;
                dcnt_q <= '0;
                pos_q  <= '0;
            end else begin
                if (st_q == ST_HDR) hidx_q <= hidx_q + 3'd1;
                if (data_fire)      dcnt_q <= dcnt_q + 8'd1;
                if (emit)           pos_q  <= pos_q + 2'd1;
            end
        end
    end
endmodule

// File: rtl/anc_hdr_gen.sv
module anc_hdr_gen
    import anc_pkg::*;
(
    input  anc_desc_t          desc,
    input  logic [HIDX_W-1:0]  hidx,
    output logic [WORD_W-1:0]  word
);
    logic late;
    assign late = (desc.line >= LINE_W'(LATE_LINE));

    always_comb begin
        case (hidx)
            3'd0:    word = FLAG_LO;
            3'd1:    word = FLAG_HI;
            3'd2:    word = FLAG_HI;
            3'd3:    word = desc.raw ? RAW_MARK : byte_word(did_code(desc.field2, late));
            3'd4:    word = byte_word({5'b00000, desc.fmt});
            3'd5:    word = byte_word(word_count(desc.len));
            3'd6:    word = byte_word(desc.line[7:0]);
            default: word = byte_word(status_byte(desc));
        endcase
    end
endmodule

// File: rtl/anc_csum.sv
module anc_csum
    import anc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add,
    input  logic [BYTE_W-1:0] data,
    output logic [BYTE_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + data;
        end
    end
endmodule

// File: rtl/anc_vbi_fmt.sv
module anc_vbi_fmt
    import anc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        desc_valid,
    output logic        desc_ready,
    input  logic        desc_raw,
    input  logic        desc_field,
    input  logic [9:0]  desc_line,
    input  logic [2:0]  desc_fmt,
    input  logic        desc_match1,
    input  logic        desc_match2,
    input  logic        desc_err,
    input  logic [7:0]  desc_len,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [9:0]  in_data,
    output logic        out_valid,
    output logic [9:0]  out_word
);
    anc_desc_t         desc_in, desc_q;
    anc_state_e        state;
    logic [HIDX_W-1:0] hidx;
    logic              emit, data_fire, desc_fire;
    logic [BYTE_W-1:0] csum;
    logic [WORD_W-1:0] hdr_word, word_d;

    assign desc_fire = desc_valid && desc_ready;

    always_comb begin
        desc_in.raw    = desc_raw;
        desc_in.field2 = desc_field;
        desc_in.line   = desc_line;
        desc_in.fmt    = desc_fmt;
        desc_in.match1 = desc_match1;
        desc_in.match2 = desc_match2;
        desc_in.err    = desc_err;
        desc_in.len    = desc_len;
    end

    anc_desc_reg u_desc (
        .clk  (clk),
        .rst  (rst),
        .load (desc_fire),
        .d_in (desc_in),
        .d_q  (desc_q)
    );

    anc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .desc_fire  (desc_fire),
        .raw        (desc_q.raw),
        .len        (desc_q.len),
        .in_valid   (in_valid),
        .state      (state),
        .hidx       (hidx),
        .emit       (emit),
        .data_fire  (data_fire),
        .desc_ready (desc_ready),
        .in_ready   (in_ready)
    );

    anc_hdr_gen u_hdr (
        .desc (desc_q),
        .hidx (hidx),
        .word (hdr_word)
    );

    anc_csum u_csum (
        .clk   (clk),
        .rst   (rst),
        .clear (desc_fire),
        .add   (data_fire),
        .data  (in_data[7:0]),
        .sum   (csum)
    );

    always_comb begin
        case (state)
            ST_HDR:  word_d = hdr_word;
            ST_DATA: word_d = desc_q.raw ? in_data : byte_word(in_data[7:0]);
            ST_CSUM: word_d = byte_word(csum);
            default: word_d = FLAG_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= emit;
            out_word  <= emit ? word_d : '0;
        end
    end
endmodule

// File: rtl/anc_vbi_fmt_chk.sv
module anc_vbi_fmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       desc_valid,
    input logic       desc_ready,
    input logic       desc_raw,
    input logic       in_valid,
    input logic       in_ready,
    input logic [9:0] in_data,
    input logic       out_valid,
    input logic [9:0] out_word
);
    logic raw_seen;

    always_ff @(posedge clk) begin
        if (rst)                          raw_seen <= 1'b0;
        else if (desc_valid && desc_ready) raw_seen <= desc_raw;
    end

    // R11: never both handshakes open
    assert_hs_excl_R11: assert property (@(posedge clk) disable iff (rst)
        desc_ready |-> !in_ready);

    // R11: payload gap yields no output word
    assert_gap_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

    // R12: idle cycle yields no output word
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        desc_ready |=> !out_valid);

    // R2: packet starts with zero word two cycles after acceptance
    assert_flag_start_R2: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready) |-> ##2 (out_valid && out_word == 10'h000));

    // R7: sliced byte lands on upper lanes one cycle later
    assert_byte_lane_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !raw_seen) |=>
            (out_valid && out_word == {$past(in_data[7:0]), 2'b00}));

    // R10: raw sample passes unchanged one cycle later
    assert_raw_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && raw_seen) |=>
            (out_valid && out_word == $past(in_data)));
endmodule

bind anc_vbi_fmt anc_vbi_fmt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_raw   (desc_raw),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_word   (out_word)
);

// File: tb/anc_vbi_fmt_tb.sv
`timescale 1ns/1ps
module anc_vbi_fmt_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       desc_valid = 1'b0;
    logic       desc_ready;
    logic       desc_raw = 1'b0;
    logic       desc_field = 1'b0;
    logic [9:0] desc_line = '0;
    logic [2:0] desc_fmt = '0;
    logic       desc_match1 = 1'b0;
    logic       desc_match2 = 1'b0;
    logic       desc_err = 1'b0;
    logic [7:0] desc_len = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [9:0] in_data = '0;
    logic       out_valid;
    logic [9:0] out_word;

    int checks = 0;
    int fails  = 0;
    logic [9:0] exp_w[$];
    string      exp_t[$];

    always #2 clk = ~clk;

    anc_vbi_fmt u_dut (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_raw(desc_raw), .desc_field(desc_field), .desc_line(desc_line),
        .desc_fmt(desc_fmt), .desc_match1(desc_match1), .desc_match2(desc_match2),
        .desc_err(desc_err), .desc_len(desc_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_word(out_word)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_w(input logic [9:0] w, input string tag);
        exp_w.push_back(w);
        exp_t.push_back(tag);
    endtask

    // reference: compare every output word against the queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_w.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R12 actual=%h expected=no word", out_word);
            end else begin
                check(exp_t.pop_front(), out_word, exp_w.pop_front());
            end
        end
    end

    task automatic send(input bit raw, input bit f2, input int line, input int fmt,
                        input bit m1, input bit m2, input bit er, input int n,
                        input int seed, input bit gaps);
        logic [9:0] d[$];
        int sum = 0;
        int nw, fill;
        for (int i = 0; i < n; i++) d.push_back(10'((seed * 53 + i * 17 + 3) % 1024));
        expect_w(10'h000, raw ? "R10" : "R2");
        expect_w(10'h3FF, raw ? "R10" : "R2");
        expect_w(10'h3FF, raw ? "R10" : "R2");
        if (raw) begin
            expect_w(10'h180, "R10");
            for (int i = 0; i < n; i++) expect_w(d[i], "R10");
        end else begin
            logic [7:0] did;
            if (!f2) did = (line < 24) ? 8'h91 : 8'h53;
            else     did = (line < 24) ? 8'h55 : 8'h97;
            nw = (n + 4) / 4;
            expect_w({did, 2'b00}, "R3");
            expect_w({5'b0, 3'(fmt), 2'b00}, "R4");
            expect_w({8'(nw), 2'b00}, "R5");
            expect_w({8'(line % 256), 2'b00}, "R6");
            expect_w({3'b000, er, m1, m2, 2'(line / 256), 2'b00}, "R6");
            for (int i = 0; i < n; i++) begin
                expect_w({d[i][7:0], 2'b00}, "R7");
                sum = (sum + int'(d[i][7:0])) % 256;
            end
            expect_w({8'(sum), 2'b00}, "R8");
            fill = 4 * nw - (n + 1);
            for (int i = 0; i < fill; i++) expect_w(10'h000, "R9");
        end
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_raw = raw; desc_field = f2; desc_line = 10'(line); desc_fmt = 3'(fmt);
        desc_match1 = m1; desc_match2 = m2; desc_err = er; desc_len = 8'(n);
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            while (!in_ready) @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;   // R11 gap
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = d[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {9'b0, desc_ready}, 10'd1);
        check("R1", {9'b0, in_ready}, 10'd0);
        check("R1", {9'b0, out_valid}, 10'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {9'b0, desc_ready}, 10'd1);
        check("R11", {9'b0, in_ready}, 10'd0);

        send(0, 0, 10,  5, 1, 0, 0, 0,   1, 0);  // R8 empty sum, R9 fill
        send(0, 1, 300, 2, 0, 0, 1, 7,   2, 1);  // R3 97h, R6 high line bits, gaps
        send(0, 0, 24,  7, 0, 1, 0, 3,   3, 0);  // R3 53h boundary, no fill
        send(0, 1, 23,  1, 1, 1, 1, 12,  4, 1);  // R3 55h
        send(0, 0, 23,  0, 0, 0, 0, 255, 5, 0);  // R5 max count, R8 wrap
        send(1, 0, 40,  0, 0, 0, 0, 5,   6, 1);  // R10 raw
        send(1, 1, 5,   0, 0, 0, 0, 0,   7, 0);  // R10 raw empty
        send(0, 0, 600, 4, 1, 0, 1, 4,   8, 0);  // R6 line bits 10

        while (exp_w.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);              // R12 quiet between packets
        check("R12", 10'(exp_w.size()), 10'd0);
        check("R11", {9'b0, desc_ready}, 10'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule